// File: doc/BRIEF.md
# Paged Program Counter and Status Unit

This block holds the 13-bit instruction address of a small 8-bit controller core, the return-address stack for subroutine calls, and the 8-bit status word. Program space is divided into eight pages of 1K words. A 3-bit page field kept in the status word supplies the upper three address bits whenever the flow of control is redirected. That happens on a jump, on a call, or on a direct write of the counter's low byte. Returns take the whole saved address from the stack and do not touch the page field.

The status word also carries two power-management bits. The timeout bit is driven by sleep, watchdog-clear and watchdog time-out events. The power-down bit is driven by sleep and watchdog-clear. Software cannot write either bit. The other fields are the zero flag, the digit (nibble) carry and the carry, which the ALU loads after an operation. The instruction decoder drives one-cycle strobes into the block, and the counter and status word are visible on its outputs.

Top module: `pcu_top`

## Requirements
- R1: While reset is active, and on the first cycle after it, the counter reads 0x0000 and the status word reads 0x18. That value is page 0, timeout bit 1, power-down bit 1 and all flags 0.
- R2: A sequential fetch adds one to the full 13-bit counter. The increment ignores page boundaries, and 0x1FFF wraps to 0x0000.
- R3: A jump loads counter bits 12..10 from the status page field (status bits 7..5) and loads bits 9..0 from the 10-bit address input.
- R4: A low-byte write loads bits 12..10 from the page field, clears bits 9..8 and puts the 8-bit data input in bits 7..0.
- R5: A call saves the current counter plus one and then loads the counter as a jump does. A return restores the saved 13-bit value exactly and leaves the page field unchanged.
- R6: The stack holds 8 entries. A ninth unreturned call overwrites the oldest entry, so the following eight returns yield the eight most recent saved addresses, newest first.
- R7: A return on an empty stack yields the entry that was popped last (the oldest one), and the stack stays empty.
- R8: A sleep event sets the timeout bit (status bit 4) to 1 and clears the power-down bit (status bit 3) to 0. A watchdog-clear sets both to 1. A watchdog time-out clears the timeout bit and leaves the power-down bit as it was.
- R9: When a time-out falls in the same cycle as a sleep or a watchdog-clear, the timeout bit ends up 0. The power-down bit still follows the sleep or the watchdog-clear.
- R10: A software write of the status word loads bits 7..5 and 2..0 from the data input. Bits 4..3 keep their previous values.
- R11: An ALU update loads the zero flag (bit 2), the digit carry (bit 1) and the carry (bit 0). When a software status write happens in the same cycle, the written values win for those bits.
- R12: When several control strobes arrive in one cycle, exactly one takes effect, in this order: return, then call, then jump, then low-byte write, then sequential fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also treated as power-on |
| fetch_i | input | 1 | Advance to the next sequential address |
| jump_i | input | 1 | Jump to page:address |
| call_i | input | 1 | Save return address and jump |
| low_wr_i | input | 1 | Direct write of the counter's low byte |
| ret_i | input | 1 | Return to the saved address |
| sleep_i | input | 1 | Sleep command event |
| wdclr_i | input | 1 | Watchdog-clear command event |
| wdto_i | input | 1 | Watchdog time-out event |
| tgt_addr_i | input | 10 | In-page target address for jump and call |
| low_data_i | input | 8 | Data for a low-byte write |
| alu_upd_i | input | 1 | Load the ALU flags |
| alu_zero_i | input | 1 | ALU result was zero |
| alu_dc_i | input | 1 | ALU digit carry |
| alu_c_i | input | 1 | ALU carry |
| st_wr_i | input | 1 | Software write of the status word |
| st_data_i | input | 8 | Status write data |
| pc_o | output | 13 | Current program counter |
| status_o | output | 8 | Status word: page[7:5], timeout[4], power-down[3], zero[2], digit carry[1], carry[0] |

## Verification
Two events can land in the same cycle on the timeout bit: a watchdog time-out together with a sleep, or a time-out together with a watchdog-clear. The bench raises both strobes in one cycle and checks two things. The timeout bit must read 0. The power-down bit must still follow the sleep or watchdog-clear. A second kind of collision is a software status write together with an ALU flag update. It is judged by whether the flag bits carry the written data and not the ALU results. Colliding control strobes are judged by which target the counter holds afterwards.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam int PC_W      = 13;
    localparam int PAGE_W    = 3;
    localparam int OFS_W     = PC_W - PAGE_W;
    localparam int DATA_W    = 8;
    localparam int STK_DEPTH = 8;

    localparam int ST_C   = 0;
    localparam int ST_DC  = 1;
    localparam int ST_Z   = 2;
    localparam int ST_PD  = 3;
    localparam int ST_TO  = 4;
    localparam int ST_PG  = 5;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_SEQ,
        SRC_JMP,
        SRC_CALL,
        SRC_LOW,
        SRC_RET
    } pc_src_e;
endpackage

// File: rtl/pcu_src_sel.sv
module pcu_src_sel
    import pcu_pkg::*;
(
    input  logic    fetch_i,
    input  logic    jump_i,
    input  logic    call_i,
    input  logic    low_wr_i,
    input  logic    ret_i,
    output pc_src_e src_o
);
    always_comb begin
        if (ret_i)         src_o = SRC_RET;
        else if (call_i)   src_o = SRC_CALL;
        else if (jump_i)   src_o = SRC_JMP;
        else if (low_wr_i) src_o = SRC_LOW;
        else if (fetch_i)  src_o = SRC_SEQ;
        else               src_o = SRC_HOLD;
    end
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_val_i,
    output logic [W-1:0] top_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [CNT_W-1:0] cnt;
    } stk_ctl_t;

    stk_ctl_t         ctl_d, ctl_q;
    logic [W-1:0]     mem_d [DEPTH];
    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] ptr_inc, ptr_dec;

    always_comb begin
        ptr_inc = (ctl_q.ptr == PTR_W'(DEPTH - 1)) ? '0 : ctl_q.ptr + 1'b1;
        ptr_dec = (ctl_q.ptr == '0) ? PTR_W'(DEPTH - 1) : ctl_q.ptr - 1'b1;
        top_o   = (ctl_q.cnt == '0) ? mem_q[ctl_q.ptr] : mem_q[ptr_dec];
    end

    always_comb begin
        ctl_d = ctl_q;
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (push_i) begin
            mem_d[ctl_q.ptr] = push_val_i;
            ctl_d.ptr        = ptr_inc;
            if (ctl_q.cnt != CNT_W'(DEPTH)) ctl_d.cnt = ctl_q.cnt + 1'b1;
        end else if (pop_i && ctl_q.cnt != '0) begin
            ctl_d.ptr = ptr_dec;
            ctl_d.cnt = ctl_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            ctl_q <= ctl_d;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end
endmodule

// File: rtl/pcu_status.sv
module pcu_status
    import pcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_wr_i,
    input  logic [DATA_W-1:0] st_data_i,
    input  logic              alu_upd_i,
    input  logic              alu_zero_i,
    input  logic              alu_dc_i,
    input  logic              alu_c_i,
    input  logic              sleep_i,
    input  logic              wdclr_i,
    input  logic              wdto_i,
    output logic [DATA_W-1:0] status_o
);
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              to;
        logic              pd;
        logic              z;
        logic              dc;
        logic              c;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (alu_upd_i) begin
            st_d.z  = alu_zero_i;
            st_d.dc = alu_dc_i;
            st_d.c  = alu_c_i;
        end
        if (st_wr_i) begin
            st_d.page = st_data_i[ST_PG +: PAGE_W];
            st_d.z    = st_data_i[ST_Z];
            st_d.dc   = st_data_i[ST_DC];
            st_d.c    = st_data_i[ST_C];
        end
        if (wdto_i)                  st_d.to = 1'b0;
        else if (sleep_i || wdclr_i) st_d.to = 1'b1;
        if (wdclr_i)                 st_d.pd = 1'b1;
        else if (sleep_i)            st_d.pd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.to <= 1'b1;
            st_q.pd <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q;
endmodule

// File: rtl/pcu_top.sv
module pcu_top
    import pcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_i,
    input  logic              jump_i,
    input  logic              call_i,
    input  logic              low_wr_i,
    input  logic              ret_i,
    input  logic              sleep_i,
    input  logic              wdclr_i,
    input  logic              wdto_i,
    input  logic [OFS_W-1:0]  tgt_addr_i,
    input  logic [DATA_W-1:0] low_data_i,
    input  logic              alu_upd_i,
    input  logic              alu_zero_i,
    input  logic              alu_dc_i,
    input  logic              alu_c_i,
    input  logic              st_wr_i,
    input  logic [DATA_W-1:0] st_data_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [DATA_W-1:0] status_o
);
    localparam int GAP_W = OFS_W - DATA_W;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;

    pc_state_t         pc_d, pc_q;
    pc_src_e           src;
    logic [PC_W-1:0]   pc_inc;
    logic [PC_W-1:0]   stk_top;
    logic [PAGE_W-1:0] page;
    logic              push, pop;

    pcu_src_sel u_sel (
        .fetch_i  (fetch_i),
        .jump_i   (jump_i),
        .call_i   (call_i),
        .low_wr_i (low_wr_i),
        .ret_i    (ret_i),
        .src_o    (src)
    );

    pcu_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_wr_i    (st_wr_i),
        .st_data_i  (st_data_i),
        .alu_upd_i  (alu_upd_i),
        .alu_zero_i (alu_zero_i),
        .alu_dc_i   (alu_dc_i),
        .alu_c_i    (alu_c_i),
        .sleep_i    (sleep_i),
        .wdclr_i    (wdclr_i),
        .wdto_i     (wdto_i),
        .status_o   (status_o)
    );

    pcu_ret_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .pop_i      (pop),
        .push_val_i (pc_inc),
        .top_o      (stk_top)
    );

    assign page   = status_o[ST_PG +: PAGE_W];
    assign pc_inc = pc_q.pc + 1'b1;
    assign push   = (src == SRC_CALL);
    assign pop    = (src == SRC_RET);

    always_comb begin
        pc_d = pc_q;
        case (src)
            SRC_SEQ:           pc_d.pc = pc_inc;
            SRC_JMP, SRC_CALL: pc_d.pc = {page, tgt_addr_i};
            SRC_LOW:           pc_d.pc = {page, {GAP_W{1'b0}}, low_data_i};
            SRC_RET:           pc_d.pc = stk_top;
            default:           pc_d.pc = pc_q.pc;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc_o = pc_q.pc;
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk
    import pcu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_i,
    input logic              jump_i,
    input logic              call_i,
    input logic              low_wr_i,
    input logic              ret_i,
    input logic              sleep_i,
    input logic              wdclr_i,
    input logic              wdto_i,
    input logic [OFS_W-1:0]  tgt_addr_i,
    input logic [DATA_W-1:0] low_data_i,
    input logic              alu_upd_i,
    input logic              alu_zero_i,
    input logic              alu_dc_i,
    input logic              alu_c_i,
    input logic              st_wr_i,
    input logic [DATA_W-1:0] st_data_i,
    input logic [PC_W-1:0]   pc_o,
    input logic [DATA_W-1:0] status_o
);
    logic only_seq, only_jmp, only_low;
    assign only_seq = fetch_i && !ret_i && !call_i && !jump_i && !low_wr_i;
    assign only_jmp = jump_i && !ret_i && !call_i;
    assign only_low = low_wr_i && !ret_i && !call_i && !jump_i;

    p_fetch_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        only_seq |=> pc_o == PC_W'($past(pc_o) + 1'b1));

    p_jump_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        only_jmp |=> pc_o == {$past(status_o[ST_PG +: PAGE_W]), $past(tgt_addr_i)});

    p_low_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        only_low |=> pc_o[OFS_W-1:DATA_W] == '0 && pc_o[DATA_W-1:0] == $past(low_data_i));

    p_ret_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !st_wr_i) |=> $stable(status_o[ST_PG +: PAGE_W]));

    p_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !wdclr_i && !wdto_i) |=> status_o[ST_TO] && !status_o[ST_PD]);

    p_wdto_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdto_i |=> !status_o[ST_TO]);

    p_ro_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_i && !sleep_i && !wdclr_i && !wdto_i) |=> $stable(status_o[ST_PD +: 2]));

    p_alu_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_upd_i && !st_wr_i) |=>
            status_o[ST_C +: 3] == {$past(alu_zero_i), $past(alu_dc_i), $past(alu_c_i)});
endmodule

bind pcu_top pcu_chk u_chk (.*);

// File: tb/tb_pcu_top.sv
`timescale 1ns/1ps
module tb_pcu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_i, jump_i, call_i, low_wr_i, ret_i;
    logic        sleep_i, wdclr_i, wdto_i;
    logic [9:0]  tgt_addr_i;
    logic [7:0]  low_data_i;
    logic        alu_upd_i, alu_zero_i, alu_dc_i, alu_c_i;
    logic        st_wr_i;
    logic [7:0]  st_data_i;
    logic [12:0] pc_o;
    logic [7:0]  status_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pcu_top dut (.*);

    task automatic idle();
        fetch_i = 0; jump_i = 0; call_i = 0; low_wr_i = 0; ret_i = 0;
        sleep_i = 0; wdclr_i = 0; wdto_i = 0; tgt_addr_i = '0; low_data_i = '0;
        alu_upd_i = 0; alu_zero_i = 0; alu_dc_i = 0; alu_c_i = 0;
        st_wr_i = 0; st_data_i = '0;
    endtask

    task automatic cyc();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 pc in reset", pc_o, 0);
        check("R1 status in reset", status_o, 8'h18);
        rst_n = 1;
        @(posedge clk); #1;
    endtask

    task automatic wr_stat(input logic [7:0] d);
        st_wr_i = 1; st_data_i = d; cyc();
    endtask

    task automatic do_jump(input logic [9:0] a);
        jump_i = 1; tgt_addr_i = a; cyc();
    endtask

    task automatic do_call(input logic [9:0] a);
        call_i = 1; tgt_addr_i = a; cyc();
    endtask

    task automatic do_ret();
        ret_i = 1; cyc();
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 pc after reset", pc_o, 0);
        check("R1 status after reset", status_o, 8'h18);
    endtask

    task automatic t_jump_fetch();
        wr_stat(8'hE0);
        do_jump(10'h3FE);
        check("R3 jump page7", pc_o, 13'h1FFE);
        fetch_i = 1; cyc();
        check("R2 fetch", pc_o, 13'h1FFF);
        fetch_i = 1; cyc();
        check("R2 wrap", pc_o, 13'h0000);
        wr_stat(8'h20);
        do_jump(10'h3FF);
        fetch_i = 1; cyc();
        check("R2 crosses page", pc_o, 13'h0800);
    endtask

    task automatic t_low_write();
        wr_stat(8'h40);
        do_jump(10'h3FF);
        low_wr_i = 1; low_data_i = 8'hA5; cyc();
        check("R4 low write", pc_o, 13'h08A5);
    endtask

    task automatic t_call_ret();
        wr_stat(8'h20);
        do_jump(10'h010);
        wr_stat(8'hA0);
        do_call(10'h123);
        check("R5 call target", pc_o, 13'h1523);
        wr_stat(8'h60);
        do_ret();
        check("R5 return addr", pc_o, 13'h0411);
        check("R5 page kept", status_o[7:5], 3);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 1; i <= 9; i++) do_call(10'(i * 16));
        for (int i = 9; i >= 2; i--) begin
            do_ret();
            check("R6 pop order", pc_o, (i - 1) * 16 + 1);
        end
        do_ret();
        check("R7 underflow", pc_o, 17);
        do_ret();
        check("R7 underflow again", pc_o, 17);
    endtask

    task automatic t_power_bits();
        do_reset();
        sleep_i = 1; cyc();
        check("R8 sleep", status_o[4:3], 2'b10);
        wdto_i = 1; cyc();
        check("R8 timeout", status_o[4:3], 2'b00);
        wdclr_i = 1; cyc();
        check("R8 wdclr", status_o[4:3], 2'b11);
        wdto_i = 1; sleep_i = 1; cyc();
        check("R9 timeout+sleep", status_o[4:3], 2'b00);
        wdto_i = 1; wdclr_i = 1; cyc();
        check("R9 timeout+wdclr", status_o[4:3], 2'b01);
    endtask

    task automatic t_stat_write();
        wr_stat(8'hFF);
        check("R10 write ones", status_o, 8'hEF);
        wr_stat(8'h10);
        check("R10 write T", status_o, 8'h08);
    endtask

    task automatic t_alu();
        alu_upd_i = 1; alu_zero_i = 1; alu_c_i = 1; cyc();
        check("R11 flags 101", status_o[2:0], 3'b101);
        alu_upd_i = 1; alu_dc_i = 1; cyc();
        check("R11 flags 010", status_o[2:0], 3'b010);
        alu_upd_i = 1; st_wr_i = 1; st_data_i = 8'h07; cyc();
        check("R11 write wins", status_o[2:0], 3'b111);
    endtask

    task automatic t_priority();
        wr_stat(8'h00);
        do_jump(10'h050);
        call_i = 1; fetch_i = 1; jump_i = 1; tgt_addr_i = 10'h200; cyc();
        check("R12 call over jump/fetch", pc_o, 13'h0200);
        ret_i = 1; jump_i = 1; low_wr_i = 1; tgt_addr_i = 10'h300; cyc();
        check("R12 ret first", pc_o, 13'h0051);
        low_wr_i = 1; fetch_i = 1; low_data_i = 8'h3C; cyc();
        check("R12 low over fetch", pc_o, 13'h003C);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        t_reset();
        t_jump_fetch();
        t_low_write();
        t_call_ret();
        t_overflow();
        t_power_bits();
        t_stat_write();
        t_alu();
        t_priority();
        finish_run();
    end
endmodule